// File: doc/BRIEF.md
# Strided Bank Request Issuer with Bypass Buffer

This block sits in front of an interleaved memory built from a prime-friendly number of banks, 2^K - 1 of them. Each of several request sources hands it a vector access as a base address, a stride and an element count with a one-cycle start pulse. The block walks the addresses, works out which bank each element falls in, and sends each element out on that bank's issue lane. A bank that has just accepted an element stays occupied for a fixed number of cycles. Memory contents, data return and write data are not part of this block. Each bank is modelled only as a countdown timer.

An element whose bank is occupied is parked in a small age-ordered waiting buffer. It does not hold up the sources. Elements headed for idle banks, from either source, go straight past the parked ones. When a bank comes free, the oldest parked element for that bank goes first. Each source raises a busy flag while any of its elements is still unissued. It gives a single completion pulse in the cycle its last element appears on a lane.

Top module: `sbank_arb`

## Requirements
- R1: Element i of a request from source s goes out with address base + i*stride, taken modulo 2^ADDR_W. Its tag carries the source number in the upper SRC_W bits and i in the low CNT_W bits.
- R2: An element whose address is A appears only on issue lane A mod (2^K - 1).
- R3: A lane strobes at most once per cycle. Two strobes on the same lane are at least BUSY cycles apart.
- R4: Every element of an accepted request is issued exactly once, whatever the stride or base, including address wrap-around.
- R5: With one source active and a stride that is not a multiple of 2^K - 1, element i strobes i+1 rising edges after the edge that samples start. The addresses must not wrap.
- R6: With one source active and a stride that is a multiple of 2^K - 1 (zero included), elements come out in index order. Element i strobes BUSY*i + 1 edges after the edge that samples start.
- R7: An element bound for an idle bank issues even while earlier elements of the other source wait on a busy bank.
- R8: When the waiting buffer is full, new address generation pauses and nothing is dropped or reordered within a bank.
- R9: busy is high from the edge after start until the last element issues. done is a one-cycle pulse in the same cycle as the last element's strobe, with busy already low.
- R10: A start while that source is busy is ignored. A start with a count of zero is ignored: no strobe, no busy, no done.
- R11: After reset, all issue strobes, busy flags and done pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | NSRC | Per-source start pulse |
| base_i | input | NSRC x ADDR_W | Per-source first element address |
| stride_i | input | NSRC x ADDR_W | Per-source address step |
| count_i | input | NSRC x CNT_W | Per-source element count |
| busy_o | output | NSRC | Source has elements not yet issued |
| done_o | output | NSRC | One-cycle completion pulse per source |
| iss_vld_o | output | 2^K-1 | Issue strobe per bank lane |
| iss_addr_o | output | (2^K-1) x ADDR_W | Element address per lane |
| iss_tag_o | output | (2^K-1) x (SRC_W+CNT_W) | Source and element index per lane |

## Verification
The bench uses the default build: K = 3 (seven banks), a four-entry waiting buffer, BUSY = 6, two sources and 16-bit addresses. With seven banks, sweeping strides 0 to 15 covers every residue, both the conflict-free and the same-bank patterns, and the exact issue times of each. A count of nine overfills the four-entry buffer, so the stall path is exercised. Base addresses near the top of the 16-bit space make the bank pattern break across the wrap, and two sources running at once then give mixed conflicts that only the per-strobe address, lane, spacing and uniqueness checks can judge.

// File: rtl/sbank_pkg.sv
package sbank_pkg;
  // Default configuration shared by the issuer and its sub-blocks.
  parameter int SB_ADDR_W = 16;
  parameter int SB_K      = 3;
  parameter int SB_CNT_W  = 8;
  parameter int SB_NSRC   = 2;
  parameter int SB_DEPTH  = 4;
  parameter int SB_BUSY   = 6;
endpackage

// File: rtl/sbank_fold.sv
// Address modulo (2^K - 1) by summing K-bit chunks with end-around carry.
module sbank_fold #(
  parameter int ADDR_W = 16,
  parameter int K      = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [K-1:0]      bank_o
);
  localparam int NCH = (ADDR_W + K - 1) / K;
  localparam logic [K-1:0] MASK = {K{1'b1}};

  logic [NCH*K-1:0] pad;
  logic [K:0]       sum;
  logic [K-1:0]     acc;

  always_comb begin
    pad = '0;
    pad[ADDR_W-1:0] = addr_i;
    acc = '0;
    sum = '0;
    for (int c = 0; c < NCH; c++) begin
      sum = {1'b0, acc} + {1'b0, pad[c*K +: K]};
      acc = sum[K-1:0] + K'(sum[K]);
    end
    bank_o = (acc == MASK) ? '0 : acc;
  end
endmodule

// File: rtl/sbank_agu.sv
// Per-source strided address walker with outstanding-element tracking.
module sbank_agu #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int ICNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              take_i,
  input  logic [ICNT_W-1:0] issued_i,
  output logic              elem_vld_o,
  output logic [ADDR_W-1:0] elem_addr_o,
  output logic [CNT_W-1:0]  elem_idx_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] addr_q, stride_q;
  logic [CNT_W-1:0]  left_q, idx_q, pend_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      stride_q <= '0;
      left_q   <= '0;
      idx_q    <= '0;
      pend_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && pend_q == '0 && count_i != '0) begin
        addr_q   <= base_i;
        stride_q <= stride_i;
        left_q   <= count_i;
        idx_q    <= '0;
        pend_q   <= count_i;
      end else begin
        if (take_i) begin
          addr_q <= addr_q + stride_q;
          left_q <= left_q - 1'b1;
          idx_q  <= idx_q + 1'b1;
        end
        if (issued_i != '0) begin
          pend_q <= pend_q - CNT_W'(issued_i);
          if (pend_q == CNT_W'(issued_i)) done_q <= 1'b1;
        end
      end
    end
  end

  assign elem_vld_o  = (left_q != '0);
  assign elem_addr_o = addr_q;
  assign elem_idx_o  = idx_q;
  assign busy_o      = (pend_q != '0);
  assign done_o      = done_q;

  // R4
  take_vld_chk: assert property (@(posedge clk) disable iff (rst)
    take_i |-> elem_vld_o);
  // R4
  issue_bound_chk: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(issued_i) <= pend_q);
  // R10
  start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(stride_q));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

// File: rtl/sbank_buf.sv
// Age-ordered waiting buffer: entry 0 is the oldest, survivors compact down.
module sbank_buf #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  parameter int NPUSH = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DEPTH-1:0]          rm_i,
  input  logic [NPUSH-1:0]          push_i,
  input  logic [NPUSH-1:0][W-1:0]   ent_i,
  output logic [DEPTH-1:0]          vld_o,
  output logic [DEPTH-1:0][W-1:0]   ent_o
);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0]        vld_q, nxt_vld;
  logic [DEPTH-1:0][W-1:0] ent_q, nxt_ent;
  logic [IW:0]             n, kept;

  always_comb begin
    nxt_vld = '0;
    nxt_ent = '0;
    n = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && !rm_i[i]) begin
        nxt_vld[n[IW-1:0]] = 1'b1;
        nxt_ent[n[IW-1:0]] = ent_q[i];
        n = n + 1'b1;
      end
    end
    kept = n;
    for (int p = 0; p < NPUSH; p++) begin
      if (push_i[p] && n < (IW+1)'(DEPTH)) begin
        nxt_vld[n[IW-1:0]] = 1'b1;
        nxt_ent[n[IW-1:0]] = ent_i[p];
        n = n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      ent_q <= '0;
    end else begin
      vld_q <= nxt_vld;
      ent_q <= nxt_ent;
    end
  end

  assign vld_o = vld_q;
  assign ent_o = ent_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(kept) + $countones(push_i)) <= DEPTH);
  // R8
  packed_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_q & (vld_q + 1'b1)) == '0);
endmodule

// File: rtl/sbank_arb.sv
module sbank_arb import sbank_pkg::*; #(
  parameter int ADDR_W    = SB_ADDR_W,
  parameter int K         = SB_K,
  parameter int CNT_W     = SB_CNT_W,
  parameter int NSRC      = SB_NSRC,
  parameter int BUF_DEPTH = SB_DEPTH,
  parameter int BUSY      = SB_BUSY
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [NSRC-1:0]                               start_i,
  input  logic [NSRC-1:0][ADDR_W-1:0]                   base_i,
  input  logic [NSRC-1:0][ADDR_W-1:0]                   stride_i,
  input  logic [NSRC-1:0][CNT_W-1:0]                    count_i,
  output logic [NSRC-1:0]                               busy_o,
  output logic [NSRC-1:0]                               done_o,
  output logic [2**K-2:0]                               iss_vld_o,
  output logic [2**K-2:0][ADDR_W-1:0]                   iss_addr_o,
  output logic [2**K-2:0][$clog2(NSRC)+CNT_W-1:0]       iss_tag_o
);
  localparam int NBANK  = 2**K - 1;
  localparam int SRC_W  = $clog2(NSRC);
  localparam int TAG_W  = SRC_W + CNT_W;
  localparam int ENT_W  = K + TAG_W + ADDR_W;
  localparam int ICNT_W = $clog2(BUF_DEPTH + NSRC) + 1;
  localparam int TMR_W  = $clog2(BUSY + 1);

  logic [NSRC-1:0]                elem_vld, take, push;
  logic [NSRC-1:0][ADDR_W-1:0]    elem_addr;
  logic [NSRC-1:0][CNT_W-1:0]     elem_idx;
  logic [NSRC-1:0][K-1:0]         elem_bank;
  logic [NSRC-1:0][ICNT_W-1:0]    issued;
  logic [NSRC-1:0][ENT_W-1:0]     new_ent;
  logic [BUF_DEPTH-1:0]           bvld, rm;
  logic [BUF_DEPTH-1:0][ENT_W-1:0] bent;
  logic [NBANK-1:0]               bfree, pick_vld, claim;
  logic [NBANK-1:0][ENT_W-1:0]    pick_ent;
  logic [NBANK-1:0][TMR_W-1:0]    tmr_q;
  logic [K-1:0]                   bk;
  logic [SRC_W-1:0]               sid;
  int                             room;

  // Address walkers and bank folding, one per source.
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    sbank_agu #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ICNT_W(ICNT_W)) u_agu (
      .clk(clk), .rst(rst), .start_i(start_i[s]), .base_i(base_i[s]),
      .stride_i(stride_i[s]), .count_i(count_i[s]), .take_i(take[s]),
      .issued_i(issued[s]), .elem_vld_o(elem_vld[s]), .elem_addr_o(elem_addr[s]),
      .elem_idx_o(elem_idx[s]), .busy_o(busy_o[s]), .done_o(done_o[s]));
    sbank_fold #(.ADDR_W(ADDR_W), .K(K)) u_fold (
      .addr_i(elem_addr[s]), .bank_o(elem_bank[s]));
    assign new_ent[s] = {elem_bank[s], SRC_W'(s), elem_idx[s], elem_addr[s]};
  end

  sbank_buf #(.DEPTH(BUF_DEPTH), .W(ENT_W), .NPUSH(NSRC)) u_buf (
    .clk(clk), .rst(rst), .rm_i(rm), .push_i(push), .ent_i(new_ent),
    .vld_o(bvld), .ent_o(bent));

  for (genvar b = 0; b < NBANK; b++) begin : g_free
    assign bfree[b] = (tmr_q[b] == '0);
  end

  // Arbitration: waiting entries oldest first, then fresh elements by source.
  always_comb begin
    claim    = '0;
    pick_vld = '0;
    pick_ent = '0;
    rm       = '0;
    take     = '0;
    push     = '0;
    issued   = '0;
    room     = BUF_DEPTH;
    bk       = '0;
    sid      = '0;
    for (int i = 0; i < BUF_DEPTH; i++) begin
      bk  = bent[i][ENT_W-1 -: K];
      sid = bent[i][ADDR_W+CNT_W +: SRC_W];
      if (bvld[i] && bfree[bk] && !claim[bk]) begin
        claim[bk]    = 1'b1;
        pick_vld[bk] = 1'b1;
        pick_ent[bk] = bent[i];
        rm[i]        = 1'b1;
        issued[sid]  = issued[sid] + ICNT_W'(1);
      end else if (bvld[i]) begin
        room = room - 1;
      end
    end
    for (int s = 0; s < NSRC; s++) begin
      bk = elem_bank[s];
      if (elem_vld[s]) begin
        if (bfree[bk] && !claim[bk]) begin
          claim[bk]    = 1'b1;
          pick_vld[bk] = 1'b1;
          pick_ent[bk] = new_ent[s];
          take[s]      = 1'b1;
          issued[s]    = issued[s] + ICNT_W'(1);
        end else if (room > 0) begin
          push[s] = 1'b1;
          take[s] = 1'b1;
          room    = room - 1;
        end
      end
    end
  end

  // Registered issue lanes and per-bank occupancy timers.
  always_ff @(posedge clk) begin
    if (rst) begin
      iss_vld_o  <= '0;
      iss_addr_o <= '0;
      iss_tag_o  <= '0;
      tmr_q      <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        iss_vld_o[b] <= pick_vld[b];
        if (pick_vld[b]) begin
          iss_addr_o[b] <= pick_ent[b][ADDR_W-1:0];
          iss_tag_o[b]  <= pick_ent[b][ADDR_W +: TAG_W];
          tmr_q[b]      <= TMR_W'(BUSY - 1);
        end else if (tmr_q[b] != '0) begin
          tmr_q[b] <= tmr_q[b] - 1'b1;
        end
      end
    end
  end

  // Checking logic: strobe spacing per lane and source hits for done.
  logic [NSRC-1:0] src_hit;
  always_comb begin
    src_hit = '0;
    for (int b = 0; b < NBANK; b++)
      if (iss_vld_o[b]) src_hit[iss_tag_o[b][TAG_W-1 -: SRC_W]] = 1'b1;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    logic [TMR_W-1:0] gap_q;
    always_ff @(posedge clk) begin
      if (rst) gap_q <= TMR_W'(BUSY);
      else if (iss_vld_o[b]) gap_q <= TMR_W'(1);
      else if (gap_q < TMR_W'(BUSY)) gap_q <= gap_q + 1'b1;
    end
    // R3
    bank_gap_chk: assert property (@(posedge clk) disable iff (rst)
      iss_vld_o[b] |-> gap_q >= TMR_W'(BUSY));
    // R2
    bank_map_chk: assert property (@(posedge clk) disable iff (rst)
      iss_vld_o[b] |-> (int'(iss_addr_o[b]) % NBANK) == b);
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_dchk
    // R9
    done_last_chk: assert property (@(posedge clk) disable iff (rst)
      done_o[s] |-> src_hit[s]);
  end
endmodule

// File: tb/sbank_arb_bench.sv
module sbank_arb_bench;
  localparam int AW = 16, CW = 8, NS = 2, NB = 7, TW = 9, BUSY = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NS-1:0]          start;
  logic [NS-1:0][AW-1:0]  base, stride;
  logic [NS-1:0][CW-1:0]  cnt;
  logic [NS-1:0]          busy, done;
  logic [NB-1:0]          iv;
  logic [NB-1:0][AW-1:0]  ia;
  logic [NB-1:0][TW-1:0]  it;

  sbank_arb u_sbank_arb (
    .clk(clk), .rst(rst), .start_i(start), .base_i(base), .stride_i(stride),
    .count_i(cnt), .busy_o(busy), .done_o(done), .iss_vld_o(iv),
    .iss_addr_o(ia), .iss_tag_o(it));

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  int last_iss[NB];
  bit seen[NS][256];
  int pb[NS], ps[NS], pn[NS];
  bit exp_on[NS], exp_mul[NS];
  int c0;
  int done_cnt[NS], strb_cnt[NS];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc >= 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual %0d expected below %0d", cyc, 150000);
      summary();
    end
  end

  // Per-strobe and per-completion checks.
  always @(negedge clk) begin
    if (!rst) begin
      for (int b = 0; b < NB; b++) begin
        if (iv[b]) begin
          int s, i, a, ea, e;
          s  = int'(it[b][TW-1]);
          i  = int'(it[b][CW-1:0]);
          a  = int'(ia[b]);
          ea = (pb[s] + ps[s] * i) % 65536;
          chk(a == ea, "R1", "element address", a, ea);
          chk(i < pn[s], "R1", "element index within count", i, pn[s]);
          chk(b == a % NB, "R2", "issue lane", b, a % NB);
          chk(cyc - last_iss[b] >= BUSY, "R3", "lane spacing", cyc - last_iss[b], BUSY);
          last_iss[b] = cyc;
          chk(!seen[s][i], "R4", "element issued once", i, -1);
          seen[s][i] = 1'b1;
          strb_cnt[s]++;
          if (exp_on[s]) begin
            e = c0 + 1 + (exp_mul[s] ? BUSY * i + 1 : i + 1);
            chk(cyc == e, exp_mul[s] ? "R6" : "R5", "strobe cycle", cyc, e);
          end
        end
      end
      for (int s = 0; s < NS; s++) begin
        if (done[s]) begin
          done_cnt[s]++;
          chk(strb_cnt[s] == pn[s], "R9", "elements out at done", strb_cnt[s], pn[s]);
          chk(busy[s] == 1'b0, "R9", "busy low at done", busy[s], 0);
          if (exp_on[s]) begin
            int ed;
            ed = c0 + 1 + (exp_mul[s] ? BUSY * (pn[s] - 1) + 1 : pn[s]);
            chk(cyc == ed, "R9", "done cycle", cyc, ed);
          end
        end
      end
    end
  end

  task automatic prep(input int s, input int b, input int st, input int n, input bit ex);
    pb[s] = b; ps[s] = st; pn[s] = n;
    base[s] = AW'(b); stride[s] = AW'(st); cnt[s] = CW'(n);
    exp_on[s] = ex; exp_mul[s] = (st % NB == 0);
    for (int i = 0; i < 256; i++) seen[s][i] = 1'b0;
    strb_cnt[s] = 0; done_cnt[s] = 0;
  endtask

  // Launch the sources in mask, optionally poke a start on source 0 while busy.
  task automatic go(input logic [NS-1:0] mask, input int poke_at);
    int w;
    @(negedge clk);
    start = mask; c0 = cyc;
    @(negedge clk);
    start = '0;
    for (int s = 0; s < NS; s++)
      if (mask[s]) chk(busy[s] == 1'b1, "R9", "busy after start", busy[s], 1);
    w = 0;
    while ((busy & mask) != '0 && w < 3000) begin
      if (poke_at > 0 && w == poke_at) begin
        base[0] = 16'd999; stride[0] = 16'd1; cnt[0] = 8'd3; start[0] = 1'b1;
      end else begin
        start = '0;
      end
      @(negedge clk);
      w++;
    end
    start = '0;
    chk(w < 3000, "R9", "busy drops", w, 3000);
    repeat (BUSY + 2) @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      if (mask[s]) begin
        chk(strb_cnt[s] == pn[s], "R4", "elements issued", strb_cnt[s], pn[s]);
        chk(done_cnt[s] == 1, "R9", "single done pulse", done_cnt[s], 1);
      end
    end
  endtask

  initial begin
    int nl[3];
    nl = '{1, 4, 9};
    start = '0; base = '0; stride = '0; cnt = '0;
    for (int b = 0; b < NB; b++) last_iss[b] = -100;
    for (int s = 0; s < NS; s++) begin
      prep(s, 0, 1, 0, 1'b0);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(iv == '0, "R11", "lanes idle", iv, 0);
    chk(busy == '0, "R11", "busy low", busy, 0);
    chk(done == '0, "R11", "done low", done, 0);

    // R5 / R6 / R8: single source, every stride residue, counts past buffer depth
    for (int st = 0; st < 16; st++) begin
      for (int k = 0; k < 3; k++) begin
        prep(0, 3 * st + nl[k], st, nl[k], 1'b1);
        go(2'b01, 0);
      end
    end

    // R7 bypass: source 0 piles onto bank 0, source 1 streams through banks 1..6
    prep(0, 0, 7, 5, 1'b1);
    prep(1, 1, 1, 6, 1'b1);
    go(2'b11, 0);

    // R4 / R8: both sources, wrap-around bases, mixed conflicts
    for (int k = 0; k < 12; k++) begin
      prep(0, 16'hFFF0 + k, k + 1, 7, 1'b0);
      prep(1, 256 * k, (3 * k + 2) % 16, 8, 1'b0);
      go(2'b11, 0);
    end
    // R4 / R8: both sources stuck on one bank
    prep(0, 14, 7, 9, 1'b0);
    prep(1, 21, 0, 9, 1'b0);
    go(2'b11, 0);

    // R10: start while busy is ignored (timing and addresses of first request kept)
    prep(0, 40, 7, 6, 1'b1);
    go(2'b01, 5);

    // R10: zero-count start is ignored
    prep(0, 5, 1, 0, 1'b0);
    @(negedge clk);
    start[0] = 1'b1;
    @(negedge clk);
    start[0] = 1'b0;
    chk(busy[0] == 1'b0, "R10", "no busy for zero count", busy[0], 0);
    repeat (12) @(negedge clk);
    chk(strb_cnt[0] == 0, "R10", "no strobe for zero count", strb_cnt[0], 0);
    chk(done_cnt[0] == 0, "R10", "no done for zero count", done_cnt[0], 0);
    summary();
  end
endmodule